// File: doc/BRIEF.md
# Transmit Descriptor Completion Interrupt Logic

This block sits in the transmit side of an Ethernet-style DMA engine. It takes each transmit descriptor status word as it is fetched, waits for the pulse that marks the end of that segment's transfer to the MAC, and then writes the status word back with the ownership bit cleared. It decides whether the finished descriptor closes a frame that asked for a completion interrupt. If it does, it sets a sticky transmit status flag. The flag drives an interrupt output through an enable bit.

The interrupt-on-completion request counts only in the descriptor that is flagged as the last segment. A frame that spans several descriptors therefore raises the status flag once, when its final descriptor is written back, and not after each descriptor. A fetched descriptor that the host still owns suspends the engine. The engine stays suspended until software issues a poll pulse. Software clears the flag by writing a one to it.

Top module: `txdesc_irq`

## Requirements
- R1: During and right after synchronous reset, `tx_stat`, `irq`, `wb_valid` and `suspended` are 0 and `fetch_req` is 1.
- R2: When the engine holds an owned descriptor, a `seg_done` pulse makes `wb_valid` high for exactly one cycle, on the next clock edge. `wb_word` then equals the fetched word with bit 31 (ownership) cleared and every other bit unchanged.
- R3: When the written-back descriptor has bit 30 (interrupt on completion) and bit 29 (last segment) both set, `tx_stat` becomes 1 in the same cycle that `wb_valid` is high.
- R4: Bit 30 set in a descriptor whose bit 29 is clear is ignored. Writing back that descriptor leaves `tx_stat` at 0.
- R5: In a frame of several descriptors (bit 28 marks the first segment, bit 29 the last), `tx_stat` stays 0 through the write-back of every earlier descriptor and rises only with the write-back of the last one.
- R6: A fetched descriptor with bit 31 clear sets `suspended` to 1 and `fetch_req` to 0. In that state `seg_done` produces no write-back and no status. A `poll` pulse returns the engine to fetching, with `fetch_req` at 1.
- R7: A clear strobe with `clr_val` at 1 clears `tx_stat`. A clear strobe with `clr_val` at 0 leaves it unchanged.
- R8: If the flag is set and cleared in the same cycle, the set wins.
- R9: `irq` equals `tx_stat` AND `irq_en`.
- R10: After each write-back the engine asks for the next descriptor: `fetch_req` is 1 in the cycle in which `wb_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Fetched descriptor word is present |
| desc_word | input | 32 | Descriptor status word 0 |
| seg_done | input | 1 | End of the current segment's transfer |
| poll | input | 1 | Software resume request after a suspend |
| clr_stb | input | 1 | Write strobe to the status register |
| clr_val | input | 1 | Bit 0 of the status write (one clears) |
| irq_en | input | 1 | Transmit interrupt enable |
| fetch_req | output | 1 | Engine wants the next descriptor |
| suspended | output | 1 | Engine stopped on a host-owned descriptor |
| wb_valid | output | 1 | Write-back word is valid (one cycle) |
| wb_word | output | 32 | Status word with ownership cleared |
| tx_stat | output | 1 | Sticky transmit status flag |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench first sends single descriptors that carry both the completion request and the last-segment flag. These show that the flag rises in step with the write-back. It then sends a completion request on a descriptor without the last-segment flag, which separates the correct rule from one that honours the request on any descriptor. A three-descriptor frame with the request on both the first and the last descriptor shows that the flag does not rise early. Further sequences cover a host-owned descriptor with a stray `seg_done`, clears with each value of the written bit, a clear that lands in the setting cycle, and both settings of the enable.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int DESC_W  = 32;
    localparam int OWN_BIT = 31;
    localparam int IC_BIT  = 30;
    localparam int LS_BIT  = 29;
    localparam int FS_BIT  = 28;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'd0,
        SEQ_XFER  = 2'd1,
        SEQ_SUSP  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic own;
        logic ic;
        logic ls;
        logic fs;
    } desc_flags_t;

    function automatic desc_flags_t decode_flags(input logic [DESC_W-1:0] w);
        desc_flags_t f;
        f.own = w[OWN_BIT];
        f.ic  = w[IC_BIT];
        f.ls  = w[LS_BIT];
        f.fs  = w[FS_BIT];
        return f;
    endfunction

    // completion request honoured only in the last segment
    function automatic logic wants_irq(input desc_flags_t f);
        return f.ic & f.ls;
    endfunction

    function automatic logic [DESC_W-1:0] release_word(input logic [DESC_W-1:0] w);
        logic [DESC_W-1:0] r;
        r = w;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tdc_seq.sv
module tdc_seq
    import tdc_pkg::*;
#(
    parameter int W = DESC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         desc_valid,
    input  logic [W-1:0] desc_word,
    input  logic         seg_done,
    input  logic         poll,
    output logic         fetch_req,
    output logic         suspended,
    output logic         seg_fin,
    output logic [W-1:0] cur_word
);
    seq_state_t  state_q, state_d;
    logic [W-1:0] word_q;
    desc_flags_t  in_f;

    always_comb begin
        in_f    = decode_flags(desc_word);
        state_d = state_q;
        case (state_q)
            SEQ_FETCH: if (desc_valid) state_d = in_f.own ? SEQ_XFER : SEQ_SUSP;
            SEQ_XFER:  if (seg_done)   state_d = SEQ_FETCH;
            SEQ_SUSP:  if (poll)       state_d = SEQ_FETCH;
            default:                   state_d = SEQ_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_FETCH;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_FETCH && desc_valid)
                word_q <= desc_word;
        end
    end

    assign fetch_req = (state_q == SEQ_FETCH);
    assign suspended = (state_q == SEQ_SUSP);
    assign seg_fin   = (state_q == SEQ_XFER) && seg_done;
    assign cur_word  = word_q;
endmodule

// File: rtl/tdc_wb.sv
module tdc_wb
    import tdc_pkg::*;
#(
    parameter int W = DESC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seg_fin,
    input  logic [W-1:0] cur_word,
    output logic         wb_valid,
    output logic [W-1:0] wb_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_word  <= '0;
        end else begin
            wb_valid <= seg_fin;
            if (seg_fin)
                wb_word <= release_word(cur_word);
        end
    end
endmodule

// File: rtl/tdc_stat.sv
module tdc_stat
    import tdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_stb,
    input  logic clr_val,
    input  logic irq_en,
    output logic tx_stat,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            tx_stat <= 1'b0;
        else if (set_req)
            tx_stat <= 1'b1;
        else if (clr_stb && clr_val)
            tx_stat <= 1'b0;
    end

    assign irq = tx_stat & irq_en;
endmodule

// File: rtl/txdesc_irq.sv
module txdesc_irq
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc_word,
    input  logic              seg_done,
    input  logic              poll,
    input  logic              clr_stb,
    input  logic              clr_val,
    input  logic              irq_en,
    output logic              fetch_req,
    output logic              suspended,
    output logic              wb_valid,
    output logic [DESC_W-1:0] wb_word,
    output logic              tx_stat,
    output logic              irq
);
    logic              seg_fin;
    logic [DESC_W-1:0] cur_word;
    logic              set_req;

    tdc_seq #(.W(DESC_W)) u_seq (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_word(desc_word),
        .seg_done(seg_done), .poll(poll), .fetch_req(fetch_req),
        .suspended(suspended), .seg_fin(seg_fin), .cur_word(cur_word)
    );

    tdc_wb #(.W(DESC_W)) u_wb (
        .clk(clk), .rst(rst), .seg_fin(seg_fin), .cur_word(cur_word),
        .wb_valid(wb_valid), .wb_word(wb_word)
    );

    assign set_req = seg_fin && wants_irq(decode_flags(cur_word));

    tdc_stat u_stat (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_stb(clr_stb),
        .clr_val(clr_val), .irq_en(irq_en), .tx_stat(tx_stat), .irq(irq)
    );
endmodule

// File: rtl/txdesc_irq_chk.sv
module txdesc_irq_chk
    import tdc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              suspended,
    input logic              wb_valid,
    input logic [DESC_W-1:0] wb_word,
    input logic              tx_stat,
    input logic              irq,
    input logic              irq_en,
    input logic              clr_stb,
    input logic              clr_val
);
    assert_wb_released_R2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !wb_word[OWN_BIT]);

    assert_wb_single_R2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    assert_stat_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_stat) |-> (wb_valid && wb_word[IC_BIT] && wb_word[LS_BIT]));

    assert_susp_no_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!fetch_req && !wb_valid));

    assert_stat_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_stat) |-> $past(clr_stb && clr_val));

    assert_irq_needs_stat_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> tx_stat);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_refetch_R10: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> fetch_req);
endmodule

bind txdesc_irq txdesc_irq_chk u_chk (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .suspended(suspended),
    .wb_valid(wb_valid), .wb_word(wb_word), .tx_stat(tx_stat), .irq(irq),
    .irq_en(irq_en), .clr_stb(clr_stb), .clr_val(clr_val)
);

// File: tb/sim_txdesc_irq.sv
module sim_txdesc_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_word = '0;
    logic        seg_done = 1'b0;
    logic        poll = 1'b0;
    logic        clr_stb = 1'b0;
    logic        clr_val = 1'b0;
    logic        irq_en = 1'b0;
    logic        fetch_req, suspended, wb_valid, tx_stat, irq;
    logic [31:0] wb_word;

    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] IC  = 32'h4000_0000;
    localparam logic [31:0] LS  = 32'h2000_0000;
    localparam logic [31:0] FS  = 32'h1000_0000;

    typedef struct {
        logic [31:0] w;
        logic        st;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic stat_model = 1'b0;

    always #2 clk = ~clk;

    txdesc_irq u0 (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_word(desc_word),
        .seg_done(seg_done), .poll(poll), .clr_stb(clr_stb), .clr_val(clr_val),
        .irq_en(irq_en), .fetch_req(fetch_req), .suspended(suspended),
        .wb_valid(wb_valid), .wb_word(wb_word), .tx_stat(tx_stat), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: compare each write-back with the oldest expected item
    always @(negedge clk) begin
        if (!rst && wb_valid) begin
            if (sb.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R6 unexpected write-back actual=%h expected=none", wb_word);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " word"}, wb_word, e.w);
                check({e.req, " status"}, {31'b0, tx_stat}, {31'b0, e.st});
                check("R10 fetch_req", {31'b0, fetch_req}, 32'd1);
            end
        end
    end

    // driver: fetch one descriptor and complete its segment
    task automatic send(input logic [31:0] w, input string req, input logic clr_same);
        exp_t e;
        while (!fetch_req) @(negedge clk);
        desc_valid = 1'b1;
        desc_word  = w;
        @(negedge clk);
        desc_valid = 1'b0;
        seg_done   = 1'b1;
        if (clr_same) begin
            clr_stb = 1'b1;
            clr_val = 1'b1;
        end
        if (w[30] && w[29]) stat_model = 1'b1;
        e.w   = w & ~OWN;
        e.st  = stat_model;
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        seg_done = 1'b0;
        clr_stb  = 1'b0;
        clr_val  = 1'b0;
    endtask

    task automatic clear(input logic v);
        clr_stb = 1'b1;
        clr_val = v;
        @(negedge clk);
        clr_stb = 1'b0;
        clr_val = 1'b0;
        if (v) stat_model = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 tx_stat", {31'b0, tx_stat}, 0);
        check("R1 wb_valid", {31'b0, wb_valid}, 0);
        check("R1 fetch_req", {31'b0, fetch_req}, 1);
        check("R1 suspended", {31'b0, suspended}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {30'b0, tx_stat, suspended}, 0);

        // R2: plain owned descriptor, no completion request
        send(OWN | FS | LS | 32'h0000_05EA, "R2", 1'b0);
        @(negedge clk);

        // R3: completion request in a last segment
        send(OWN | FS | LS | IC | 32'h0000_0040, "R3", 1'b0);
        @(negedge clk);
        irq_en = 1'b1;
        #1 check("R9 irq enabled", {31'b0, irq}, 1);
        irq_en = 1'b0;
        #1 check("R9 irq disabled", {31'b0, irq}, 0);
        @(negedge clk);

        // R7: a write with bit 0 at zero has no effect, then a one clears
        clear(1'b0);
        check("R7 zero write keeps", {31'b0, tx_stat}, 1);
        clear(1'b1);
        check("R7 one write clears", {31'b0, tx_stat}, 0);
        irq_en = 1'b1;
        #1 check("R9 irq with flag clear", {31'b0, irq}, 0);
        irq_en = 1'b0;

        // R4: request on a non-last descriptor is ignored
        send(OWN | FS | IC | 32'h0000_0100, "R4", 1'b0);
        @(negedge clk);
        check("R4 no status", {31'b0, tx_stat}, 0);

        // R5: three-descriptor frame
        send(OWN | FS | IC | 32'h0000_0200, "R5 first", 1'b0);
        send(OWN | 32'h0000_0300, "R5 middle", 1'b0);
        send(OWN | LS | IC | 32'h0000_0400, "R5 last", 1'b0);
        @(negedge clk);
        check("R5 status after frame", {31'b0, tx_stat}, 1);
        clear(1'b1);

        // R6: host-owned descriptor suspends
        while (!fetch_req) @(negedge clk);
        desc_valid = 1'b1;
        desc_word  = LS | IC | FS;
        @(negedge clk);
        desc_valid = 1'b0;
        check("R6 suspended", {31'b0, suspended}, 1);
        check("R6 fetch_req low", {31'b0, fetch_req}, 0);
        seg_done = 1'b1;
        @(negedge clk);
        seg_done = 1'b0;
        check("R6 no write-back", {31'b0, wb_valid}, 0);
        @(negedge clk);
        check("R6 no status", {31'b0, tx_stat}, 0);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        check("R6 resumed", {30'b0, fetch_req, suspended}, 32'd2);

        // R8: clear in the setting cycle loses
        send(OWN | FS | LS | IC | 32'h0000_0080, "R8", 1'b1);
        @(negedge clk);
        check("R8 set wins", {31'b0, tx_stat}, 1);

        repeat (3) @(negedge clk);
        check("scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule